// File: doc/BRIEF.md
# Teletext Page Request Comparator

This block keeps the page requests for eight acquisition slots and compares every received page header against all of them in parallel. A header carries the hamming-decoded magazine number, the page tens and units digits and a four-digit hours/minutes sub-code. It also carries one error flag for each of those seven digits. Each slot holds seven 5-bit request columns. The top bit of each column is a "do care" flag that decides whether that digit takes part in the compare. Column 0 also holds a HOLD bit: while it is 0 the slot is frozen and captures nothing.

The host programs a request in two steps. It first loads a pointer that names a slot and a start column. The slot is named by a 3-bit index whose top bit picks one of two groups of four. The host then streams 5-bit data words, and the column pointer advances by itself after each word. Each header produces a one-cycle vector with one bit per slot that should capture the page. An active-low found flag follows one cycle later. Hamming decoding, packet framing and the writing of captured rows into page memory belong to the surrounding logic.

Top module: `ttx_page_req_match`

## Requirements
- R1: After reset every request column is zero, so every slot is held and matches nothing; `match_vec` is 0 and `found_n` is 1.
- R2: A pointer load selects slot `cfg_slot` (bit 2 picks the group, bits 1..0 the slot in that group, bit i of `match_vec` belongs to slot i) and sets the column pointer to `cfg_start_col`; a start column of 7 selects column 0.
- R3: Each data write stores `cfg_data` into the current column of the selected slot and advances the pointer, with column 6 followed by column 0. A data write in the same cycle as a pointer load goes to the newly loaded slot and column.
- R4: Column layout: column 0 is {do-care, HOLD, magazine[2:0]}. Columns 1 to 6 each carry do-care in bit 4 and a digit in their low bits: page tens [3:0], page units [3:0], hours tens [1:0], hours units [3:0], minutes tens [2:0], minutes units [3:0].
- R5: A digit is compared only when its do-care bit is 1; a slot with HOLD set and no do-care bits matches every header.
- R6: A slot whose HOLD bit is 0 never matches.
- R7: `hdr_err` bit c flags the digit of column c (bit 0 magazine through bit 6 minutes units). An error on a compared digit blocks the match. An error on a digit that is not compared has no effect.
- R8: `match_vec` shows, in the cycle after `hdr_valid`, every slot that matches (several may be set together) and is zero in every other cycle.
- R9: One cycle after each `match_vec` result, `found_n` goes low if any slot matched that header and high if none did; it holds its value between headers.
- R10: A header that arrives in the same cycle as a data write is compared against the request contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ptr_we | input | 1 | Load slot index and start column |
| cfg_slot | input | 3 | Slot index {group, slot in group} |
| cfg_start_col | input | 3 | Start column for the following data writes |
| cfg_data_we | input | 1 | Write one request column |
| cfg_data | input | 5 | Request column value |
| hdr_valid | input | 1 | Header digits valid for one cycle |
| hdr_mag | input | 3 | Magazine number |
| hdr_pt | input | 4 | Page tens |
| hdr_pu | input | 4 | Page units |
| hdr_ht | input | 2 | Hours tens |
| hdr_hu | input | 4 | Hours units |
| hdr_mt | input | 3 | Minutes tens |
| hdr_mu | input | 4 | Minutes units |
| hdr_err | input | 7 | Hamming error per digit, in column order |
| match_vec | output | 8 | Slots that capture the last header |
| found_n | output | 1 | Low when the last header matched any slot |

## Verification
A host write and a header compare can land in the same cycle. The case to watch is a data word that rewrites the magazine column of a slot while a header for the old magazine is being compared. The bench provokes this on purpose, and its reference model resolves it by computing the match from the stored requests before it applies the write. The same applies to a pointer load combined with a data write, which has to land at the new position. The bench then sends two further headers, one for each magazine, to show that the old value was used for the compare and the new value was stored.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

  localparam int NUM_COLS  = 7;
  localparam int COL_W     = 5;
  localparam int COL_PTR_W = 3;
  localparam int DIG_W     = 4;
  localparam int DC_BIT    = 4;
  localparam int HOLD_BIT  = 3;

  typedef logic [COL_W-1:0] col_t;

  typedef struct packed {
    logic [2:0] mag;
    logic [3:0] pt;
    logic [3:0] pu;
    logic [1:0] ht;
    logic [3:0] hu;
    logic [2:0] mt;
    logic [3:0] mu;
  } hdr_t;

  // Significant bits of the digit held in each column.
  function automatic logic [DIG_W-1:0] digit_mask(input int col);
    case (col)
      0:       return 4'b0111;
      3:       return 4'b0011;
      5:       return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // Header digit that lines up with a request column.
  function automatic logic [DIG_W-1:0] hdr_digit(input hdr_t h, input int col);
    case (col)
      0:       return {1'b0, h.mag};
      1:       return h.pt;
      2:       return h.pu;
      3:       return {2'b00, h.ht};
      4:       return h.hu;
      5:       return {1'b0, h.mt};
      default: return h.mu;
    endcase
  endfunction

endpackage

// File: rtl/ttx_req_loader.sv
module ttx_req_loader
  import ttx_req_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ptr_we,
  input  logic [SLOT_W-1:0]    ptr_slot,
  input  logic [COL_PTR_W-1:0] ptr_col,
  input  logic                 data_we,
  output logic [N_SLOTS-1:0]   wr_en,
  output logic [COL_PTR_W-1:0] wr_col
);

  logic [COL_PTR_W-1:0] col_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [COL_PTR_W-1:0] load_col;
  logic [COL_PTR_W-1:0] eff_col;
  logic [SLOT_W-1:0]    eff_slot;
  logic [COL_PTR_W-1:0] next_col;

  always_comb begin
    load_col = (int'(ptr_col) >= NUM_COLS) ? '0 : ptr_col;
    eff_col  = ptr_we ? load_col : col_q;
    eff_slot = ptr_we ? ptr_slot : slot_q;
    next_col = (int'(eff_col) == NUM_COLS - 1) ? '0 : eff_col + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '0;
      slot_q <= '0;
    end else begin
      if (ptr_we) slot_q <= ptr_slot;
      if (data_we)     col_q <= next_col;
      else if (ptr_we) col_q <= load_col;
    end
  end

  always_comb begin
    wr_en = '0;
    if (data_we) wr_en[eff_slot] = 1'b1;
  end

  assign wr_col = eff_col;

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(col_q) < NUM_COLS); // R2

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (data_we && !ptr_we) |=> int'(col_q) == ((int'($past(col_q)) + 1) % NUM_COLS)); // R3

endmodule

// File: rtl/ttx_req_slot.sv
module ttx_req_slot
  import ttx_req_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [COL_PTR_W-1:0] wr_col,
  input  logic [COL_W-1:0]     wr_data,
  input  logic                 hdr_valid,
  input  hdr_t                 hdr,
  input  logic [NUM_COLS-1:0]  hdr_err,
  output logic                 hit_q
);

  col_t                cols [NUM_COLS];
  logic [NUM_COLS-1:0] col_ok;
  logic                hold;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst)                                         cols[c] <= '0;
      else if (wr_en && wr_col == COL_PTR_W'(c))       cols[c] <= wr_data;
    end

    assign col_ok[c] = !cols[c][DC_BIT] ||
                       ((((cols[c][DIG_W-1:0] ^ hdr_digit(hdr, c)) & digit_mask(c)) == '0) &&
                        !hdr_err[c]);
  end

  assign hold = cols[0][HOLD_BIT];

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hdr_valid && hold && (&col_ok);
  end

  AST_HELD_SLOT_SILENT: assert property (@(posedge clk) disable iff (rst)
    !cols[0][HOLD_BIT] |=> !hit_q); // R6

  AST_MAG_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && cols[0][DC_BIT] && hdr_err[0]) |=> !hit_q); // R7

  AST_HIT_NEEDS_HDR: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !hit_q); // R8

endmodule

// File: rtl/ttx_page_req_match.sv
module ttx_page_req_match
  import ttx_req_pkg::*;
#(
  parameter int N_GROUPS        = 2,
  parameter int SLOTS_PER_GROUP = 4
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        cfg_ptr_we,
  input  logic [$clog2(N_GROUPS*SLOTS_PER_GROUP)-1:0] cfg_slot,
  input  logic [2:0]                                  cfg_start_col,
  input  logic                                        cfg_data_we,
  input  logic [4:0]                                  cfg_data,
  input  logic                                        hdr_valid,
  input  logic [2:0]                                  hdr_mag,
  input  logic [3:0]                                  hdr_pt,
  input  logic [3:0]                                  hdr_pu,
  input  logic [1:0]                                  hdr_ht,
  input  logic [3:0]                                  hdr_hu,
  input  logic [2:0]                                  hdr_mt,
  input  logic [3:0]                                  hdr_mu,
  input  logic [6:0]                                  hdr_err,
  output logic [N_GROUPS*SLOTS_PER_GROUP-1:0]         match_vec,
  output logic                                        found_n
);

  localparam int N_SLOTS = N_GROUPS * SLOTS_PER_GROUP;
  localparam int SLOT_W  = $clog2(N_SLOTS);

  hdr_t                 hdr_s;
  logic [N_SLOTS-1:0]   wr_en;
  logic [COL_PTR_W-1:0] wr_col;
  logic                 hdr_seen_q;

  assign hdr_s = '{mag: hdr_mag, pt: hdr_pt, pu: hdr_pu, ht: hdr_ht,
                   hu: hdr_hu, mt: hdr_mt, mu: hdr_mu};

  ttx_req_loader #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_loader (
    .clk     (clk),
    .rst     (rst),
    .ptr_we  (cfg_ptr_we),
    .ptr_slot(cfg_slot),
    .ptr_col (cfg_start_col),
    .data_we (cfg_data_we),
    .wr_en   (wr_en),
    .wr_col  (wr_col)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    ttx_req_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en[s]),
      .wr_col   (wr_col),
      .wr_data  (cfg_data),
      .hdr_valid(hdr_valid),
      .hdr      (hdr_s),
      .hdr_err  (hdr_err),
      .hit_q    (match_vec[s])
    );
  end

  // Found flag is registered from the match vector, keeping the OR off the compare path.
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_seen_q <= 1'b0;
      found_n    <= 1'b1;
    end else begin
      hdr_seen_q <= hdr_valid;
      if (hdr_seen_q) found_n <= ~(|match_vec);
    end
  end

  AST_MATCH_ONLY_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> match_vec == '0); // R8

  AST_FOUND_FOLLOWS_MATCH: assert property (@(posedge clk) disable iff (rst)
    hdr_seen_q |=> found_n == ($past(match_vec) == '0)); // R9

  AST_FOUND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !hdr_seen_q |=> $stable(found_n)); // R9

endmodule

// File: tb/test_ttx_page_req_match.sv
module test_ttx_page_req_match;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_ptr_we = 1'b0;
  logic [2:0] cfg_slot = '0;
  logic [2:0] cfg_start_col = '0;
  logic       cfg_data_we = 1'b0;
  logic [4:0] cfg_data = '0;
  logic       hdr_valid = 1'b0;
  logic [2:0] hdr_mag = '0;
  logic [3:0] hdr_pt = '0;
  logic [3:0] hdr_pu = '0;
  logic [1:0] hdr_ht = '0;
  logic [3:0] hdr_hu = '0;
  logic [2:0] hdr_mt = '0;
  logic [3:0] hdr_mu = '0;
  logic [6:0] hdr_err = '0;
  logic [7:0] match_vec;
  logic       found_n;

  always #4 clk = ~clk;

  ttx_page_req_match i_ttx_page_req_match (
    .clk(clk), .rst(rst), .cfg_ptr_we(cfg_ptr_we), .cfg_slot(cfg_slot),
    .cfg_start_col(cfg_start_col), .cfg_data_we(cfg_data_we), .cfg_data(cfg_data),
    .hdr_valid(hdr_valid), .hdr_mag(hdr_mag), .hdr_pt(hdr_pt), .hdr_pu(hdr_pu),
    .hdr_ht(hdr_ht), .hdr_hu(hdr_hu), .hdr_mt(hdr_mt), .hdr_mu(hdr_mu),
    .hdr_err(hdr_err), .match_vec(match_vec), .found_n(found_n)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Behavioural reference model
  int   req [8][7];
  int   m_ptr, m_sel;
  logic [7:0] exp_match;
  logic exp_found_n, exp_seen;
  int   wid [7] = '{3, 4, 4, 2, 4, 3, 4};

  function automatic bit model_hit(int s);
    int d [7];
    d = '{int'(hdr_mag), int'(hdr_pt), int'(hdr_pu), int'(hdr_ht),
          int'(hdr_hu), int'(hdr_mt), int'(hdr_mu)};
    if (((req[s][0] >> 3) & 1) == 0) return 0;
    for (int c = 0; c < 7; c++) begin
      if ((req[s][c] >> 4) & 1) begin
        if (hdr_err[c]) return 0;
        if ((req[s][c] & ((1 << wid[c]) - 1)) != d[c]) return 0;
      end
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 8; s++) for (int c = 0; c < 7; c++) req[s][c] = 0;
      m_ptr = 0; m_sel = 0;
      exp_match = '0; exp_found_n = 1'b1; exp_seen = 1'b0;
    end else begin
      logic [7:0] m;
      if (exp_seen) exp_found_n = (exp_match == 8'h00);
      exp_seen = hdr_valid;
      for (int s = 0; s < 8; s++) m[s] = model_hit(s);
      exp_match = hdr_valid ? m : 8'h00;
      if (cfg_ptr_we) begin
        m_sel = int'(cfg_slot);
        m_ptr = (int'(cfg_start_col) > 6) ? 0 : int'(cfg_start_col);
      end
      if (cfg_data_we) begin
        req[m_sel][m_ptr] = int'(cfg_data);
        m_ptr = (m_ptr + 1) % 7;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (match_vec !== exp_match) begin
        failures++;
        $display("FAIL %s match_vec actual=%b expected=%b t=%0t", cur_req, match_vec, exp_match, $time);
      end
      checks++;
      if (found_n !== exp_found_n) begin
        failures++;
        $display("FAIL %s found_n actual=%b expected=%b t=%0t", cur_req, found_n, exp_found_n, $time);
      end
    end
  end

  task automatic clear_in();
    cfg_ptr_we = 0; cfg_data_we = 0; hdr_valid = 0; hdr_err = '0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); clear_in(); end
  endtask

  task automatic set_ptr(int s, int c);
    @(negedge clk); clear_in();
    cfg_ptr_we = 1; cfg_slot = 3'(s); cfg_start_col = 3'(c);
  endtask

  task automatic put(int d);
    @(negedge clk); clear_in();
    cfg_data_we = 1; cfg_data = 5'(d);
  endtask

  task automatic set_hdr(int mag, int pt, int pu, int ht, int hu, int mt, int mu, int err);
    hdr_valid = 1; hdr_mag = 3'(mag); hdr_pt = 4'(pt); hdr_pu = 4'(pu);
    hdr_ht = 2'(ht); hdr_hu = 4'(hu); hdr_mt = 3'(mt); hdr_mu = 4'(mu); hdr_err = 7'(err);
  endtask

  task automatic hdr(int mag, int pt, int pu, int ht, int hu, int mt, int mu, int err);
    @(negedge clk); clear_in();
    set_hdr(mag, pt, pu, ht, hu, mt, mu, err);
  endtask

  task automatic load_req(int s, int v0, int v1, int v2, int v3, int v4, int v5, int v6);
    set_ptr(s, 0);
    put(v0); put(v1); put(v2); put(v3); put(v4); put(v5); put(v6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    // R1: reset state, all slots held
    cur_req = "R1";
    idle(2);
    hdr(0, 0, 0, 0, 0, 0, 0, 0);
    idle(3);

    // R4 / R5: slot 0 wants magazine 1 page 23, any sub-code
    cur_req = "R5";
    load_req(0, 5'b11001, 5'b10010, 5'b10011, 0, 0, 0, 0);
    // slot 3: HOLD set, no do-care bits, matches everything
    load_req(3, 5'b01000, 0, 0, 0, 0, 0, 0);
    hdr(1, 2, 3, 1, 5, 3, 0, 0);
    hdr(2, 2, 3, 1, 5, 3, 0, 0);
    idle(3);

    // R8: timed request on slot 1 (15:30), several slots at once
    cur_req = "R8";
    load_req(1, 5'b11001, 5'b10010, 5'b10011, 5'b10001, 5'b10101, 5'b10011, 5'b10000);
    hdr(1, 2, 3, 1, 5, 3, 0, 0);
    hdr(1, 2, 3, 1, 5, 3, 1, 0);
    idle(2);

    // R6: same request on slot 2 but HOLD cleared
    cur_req = "R6";
    load_req(2, 5'b10001, 5'b10010, 5'b10011, 0, 0, 0, 0);
    hdr(1, 2, 3, 1, 5, 3, 0, 0);
    idle(2);

    // R7: error on compared page units, then on hours units only
    cur_req = "R7";
    hdr(1, 2, 3, 1, 5, 3, 0, 7'b0000100);
    hdr(1, 2, 3, 1, 5, 3, 0, 7'b0010000);
    hdr(1, 2, 3, 1, 5, 3, 0, 7'b0000001);
    idle(2);

    // R2: group 1 slot 2 is slot 6; start column 7 lands on column 0
    cur_req = "R2";
    load_req(6, 5'b11010, 0, 0, 0, 0, 0, 0);
    set_ptr(5, 7);
    put(5'b11100);
    hdr(2, 0, 0, 0, 0, 0, 0, 0);
    hdr(4, 0, 0, 0, 0, 0, 0, 0);
    idle(2);

    // R3: auto-increment with wrap from column 6 to column 0
    cur_req = "R3";
    set_ptr(4, 5);
    put(5'b10010); put(5'b10001); put(5'b11011);
    hdr(3, 0, 0, 0, 0, 2, 1, 0);
    hdr(3, 0, 0, 0, 0, 2, 2, 0);
    // R3: data write together with pointer load goes to the new position
    @(negedge clk); clear_in();
    cfg_ptr_we = 1; cfg_slot = 3'd7; cfg_start_col = 3'd0;
    cfg_data_we = 1; cfg_data = 5'b11110;
    hdr(6, 0, 0, 0, 0, 0, 0, 0);
    idle(2);

    // R10: rewrite slot 7 magazine while a header for the old magazine arrives
    cur_req = "R10";
    set_ptr(7, 0);
    @(negedge clk); clear_in();
    cfg_data_we = 1; cfg_data = 5'b11111;
    set_hdr(6, 0, 0, 0, 0, 0, 0, 0);
    hdr(6, 0, 0, 0, 0, 0, 0, 0);
    hdr(7, 0, 0, 0, 0, 0, 0, 0);
    idle(2);

    // R9: a header that no slot wants drives found_n high, then it holds
    cur_req = "R9";
    set_ptr(3, 0); put(0);
    hdr(0, 9, 9, 0, 0, 0, 0, 0);
    idle(4);
    hdr(1, 2, 3, 0, 0, 0, 0, 0);
    idle(4);

    // Mixed traffic, headers back to back with host writes
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      @(negedge clk); clear_in();
      if (op == 0) begin
        cfg_ptr_we = 1; cfg_slot = 3'($urandom_range(0, 7)); cfg_start_col = 3'($urandom_range(0, 7));
      end
      if (op <= 3) begin
        cfg_data_we = 1; cfg_data = 5'($urandom_range(0, 31));
      end
      if (op >= 3) begin
        set_hdr(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                int'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 127)) : 0);
      end
    end
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule